// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block produces the SCL clock of an I2C master from the system clock. Two settings fix the rate: an 8-bit bit-rate divisor and a 2-bit prescale select. The select picks a multiplier of 1, 4, 16 or 64. Each half of the SCL period lasts `8 + divisor * 4^prescale` system clocks, so an SCL period that no slave stretches lasts `16 + 2 * divisor * 4^prescale` clocks. The block drives SCL only low, through an open-drain drive-low output. It watches the real line through a two-flop synchronizer. It raises one-cycle strobes that the rest of the master uses to time data bits and START/STOP.

The block is built around a four-state machine:
- IDLE: SCL is released and the counters are at zero.
- LOW: SCL is driven low for a full half-period.
- WAIT_HIGH: SCL has been released and the block waits for the synchronized line to read high.
- HIGH: the rest of the high half-period is counted.

The transitions are:
- start: IDLE to LOW, when master mode is enabled.
- release: LOW to WAIT_HIGH, when the low count expires.
- seen_high: WAIT_HIGH to HIGH, when the synchronized SCL reads high.
- next_period: HIGH to LOW, when the high count expires.
- abort: any state to IDLE, when master mode is dropped.

A slave that holds SCL low keeps the machine in WAIT_HIGH, which makes that period longer. The divisor and prescale are captured when each period starts. A change in the middle of a period therefore takes effect at the next period.

Top module: `scl_rate_gen`

## Requirements
- R1: After reset, `scl_drive_low`, `fall_stb` and `rise_stb` are all 0.
- R2: Each low phase drives `scl_drive_low` to 1 for exactly H = 8 + divisor * 4^prescale consecutive cycles.
- R3: Prescale codes 0, 1, 2 and 3 multiply the divisor by 1, 4, 16 and 64. With no stretching, the line is released for H cycles, so the period is 16 + 2 * divisor * 4^prescale cycles.
- R4: After release, the high-phase count starts only once the two-flop-synchronized SCL reads high. If a slave holds SCL low for S extra cycles, the released time becomes H + S.
- R5: `fall_stb` is 1 for exactly the first cycle of each low phase. `rise_stb` is 1 for exactly one cycle per period, in the cycle the high count begins. That is released cycle 3 with no stretching, and cycle S + 3 with stretching.
- R6: While `master_en` is 0, SCL is released and no strobe fires, whatever the divisor and prescale inputs do.
- R7: The divisor and prescale are sampled when each low phase begins. A change inside a period alters only the following period.
- R8: Clearing `master_en` releases SCL on the next cycle. Setting it again starts a fresh, full-length low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Master mode enable; 0 keeps the generator idle |
| bit_div | input | 8 | Bit-rate divisor |
| prescale | input | 2 | Prescale select: multiplier 4^prescale |
| scl_in | input | 1 | Sampled state of the SCL line (asynchronous) |
| scl_drive_low | output | 1 | 1 pulls SCL low; 0 releases it |
| fall_stb | output | 1 | One-cycle pulse in the first cycle of a low phase |
| rise_stb | output | 1 | One-cycle pulse when the high count begins |

## Verification
The assertions check four things on every cycle:
- The two strobes never fire together, and neither lasts more than one cycle.
- The machine never enters HIGH while the synchronized line is still low.
- The phase counter stays below the captured half-period.
- SCL is released in the cycle after master mode drops.

Only the bench scenarios can show the following:
- The exact phase lengths for each prescale code.
- The extra released time added by a stretching slave.
- That a divisor change inside a period is deferred to the next period.
- That re-enabling gives a full-length first low phase.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

endpackage

// File: rtl/scl_sync.sv
// Multi-stage synchronizer for the asynchronous SCL input; resets to the idle-high level.
module scl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sr;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '1;
                else        sr <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sr <= '1;
                else        sr <= {sr[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = sr[STAGES-1];
endmodule

// File: rtl/scl_half_calc.sv
// Half-period length: 8 + divisor * 4^prescale, one shifted candidate per prescale code.
module scl_half_calc #(
    parameter int DIV_W = 8,
    parameter int PS_W  = 2,
    parameter int HW    = DIV_W + 2 * ((1 << PS_W) - 1) + 1
) (
    input  logic [DIV_W-1:0] bit_div,
    input  logic [PS_W-1:0]  prescale,
    output logic [HW-1:0]    half_len
);
    localparam int NUM_PS = 1 << PS_W;

    logic [HW-1:0] cand [NUM_PS];

    generate
        for (genvar i = 0; i < NUM_PS; i++) begin : g_cand
            assign cand[i] = HW'(8) + (HW'(bit_div) << (2 * i));
        end
    endgenerate

    assign half_len = cand[prescale];
endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_rate_pkg::*;
#(
    parameter int HW       = 15,
    parameter int SYNC_LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          scl_hi,
    input  logic [HW-1:0] half_len,
    output logic          drive_low,
    output logic          fall_stb,
    output logic          rise_stb
);
    // Released cycles already spent waiting (without stretching) before HIGH is entered.
    localparam logic [HW-1:0] HIGH_TRIM = HW'(SYNC_LAT + 1);

    scl_phase_e    state, next;
    logic [HW-1:0] cnt;
    logic [HW-1:0] half_q;

    // Next-state decode
    always_comb begin
        next = state;
        unique case (state)
            PH_IDLE: if (en) next = PH_LOW;
            PH_LOW:  if (!en) next = PH_IDLE;
                     else if (cnt == '0) next = PH_WAIT;
            PH_WAIT: if (!en) next = PH_IDLE;
                     else if (scl_hi) next = PH_HIGH;
            PH_HIGH: if (!en) next = PH_IDLE;
                     else if (cnt == '0) next = PH_LOW;
            default: next = PH_IDLE;
        endcase
    end

    // State register with phase counter and per-period capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= PH_IDLE;
            cnt    <= '0;
            half_q <= '0;
        end else begin
            state <= next;
            unique case (next)
                PH_IDLE: begin
                    cnt    <= '0;
                    half_q <= '0;
                end
                PH_LOW: begin
                    if (state != PH_LOW) begin
                        half_q <= half_len;
                        cnt    <= half_len - HW'(1);
                    end else begin
                        cnt <= cnt - HW'(1);
                    end
                end
                PH_WAIT: cnt <= '0;
                PH_HIGH: begin
                    if (state != PH_HIGH) cnt <= half_q - HIGH_TRIM;
                    else                  cnt <= cnt - HW'(1);
                end
                default: cnt <= '0;
            endcase
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_low <= 1'b0;
            fall_stb  <= 1'b0;
            rise_stb  <= 1'b0;
        end else begin
            drive_low <= (next == PH_LOW);
            fall_stb  <= (next == PH_LOW)  && (state != PH_LOW);
            rise_stb  <= (next == PH_HIGH) && (state != PH_HIGH);
        end
    end

    // R4: HIGH never follows a WAIT cycle in which the synchronized line was low
    p_high_needs_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_WAIT && !scl_hi) |=> (state != PH_HIGH));

    // R2: the low count stays inside the captured half-period
    p_low_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_LOW) |-> (cnt < half_q));

    // R3: the high count stays inside the captured half-period
    p_high_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PH_HIGH) |-> (cnt < half_q));

    // R5: strobes are single-cycle and never coincide
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(fall_stb && rise_stb));
    p_fall_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);
    p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> !rise_stb);
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_rate_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int PS_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master_en,
    input  logic [DIV_W-1:0] bit_div,
    input  logic [PS_W-1:0]  prescale,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             fall_stb,
    output logic             rise_stb
);
    localparam int HW       = DIV_W + 2 * ((1 << PS_W) - 1) + 1;
    localparam int SYNC_LAT = SYNC_STAGES + 1;

    logic          scl_hi;
    logic [HW-1:0] half_len;

    scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (scl_in),
        .dout (scl_hi)
    );

    scl_half_calc #(.DIV_W(DIV_W), .PS_W(PS_W), .HW(HW)) u_calc (
        .bit_div (bit_div),
        .prescale(prescale),
        .half_len(half_len)
    );

    scl_phase_fsm #(.HW(HW), .SYNC_LAT(SYNC_LAT)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (master_en),
        .scl_hi   (scl_hi),
        .half_len (half_len),
        .drive_low(scl_drive_low),
        .fall_stb (fall_stb),
        .rise_stb (rise_stb)
    );

    // R6 / R8: leaving master mode releases SCL on the next cycle
    p_idle_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !scl_drive_low);

    // R6: no strobes while master mode is off for two cycles running
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_en && $past(!master_en)) |=> (!fall_stb && !rise_stb));
endmodule

// File: tb/tb_scl_rate_gen.sv
`timescale 1ns/1ps
module tb_scl_rate_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       master_en = 1'b0;
    logic [7:0] bit_div = '0;
    logic [1:0] prescale = '0;
    logic       scl_in;
    logic       scl_drive_low, fall_stb, rise_stb;

    int checks = 0;
    int fails  = 0;
    int stretch_len = 0;
    int hold_cnt = 0;

    always #2.5 clk = ~clk;

    scl_rate_gen dut (
        .clk(clk), .rst_n(rst_n), .master_en(master_en),
        .bit_div(bit_div), .prescale(prescale), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .fall_stb(fall_stb), .rise_stb(rise_stb)
    );

    // Bus model: a slave keeps SCL low for stretch_len cycles after the master releases it
    always @(posedge clk) begin
        if (scl_drive_low) hold_cnt <= stretch_len;
        else if (hold_cnt > 0) hold_cnt <= hold_cnt - 1;
    end
    assign scl_in = !scl_drive_low && (hold_cnt == 0);

    // Vector table: divisor, prescale, expected half-period H = 8 + div*4^ps
    localparam int NV = 7;
    localparam int VD [NV] = '{0, 5, 3, 2, 1, 10, 255};
    localparam int VP [NV] = '{0, 0, 1, 2, 3, 3, 3};
    localparam int VH [NV] = '{8, 13, 20, 40, 72, 648, 16328};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_fall();
        @(negedge clk);
        while (!fall_stb) @(negedge clk);
    endtask

    // Called at a negedge where fall_stb is 1; returns at the next such negedge
    task automatic measure(output int lo, output int hi, output int rises, output int rpos);
        lo = 0; hi = 0; rises = 0; rpos = -1;
        while (scl_drive_low) begin
            lo++;
            @(negedge clk);
        end
        while (!fall_stb) begin
            if (rise_stb) begin
                rises++;
                rpos = hi;
            end
            hi++;
            @(negedge clk);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int lo, hi, rs, rp, cnt_act;
        // R1: reset values
        repeat (3) @(negedge clk);
        chk("R1 drive", int'(scl_drive_low), 0);
        chk("R1 fall_stb", int'(fall_stb), 0);
        chk("R1 rise_stb", int'(rise_stb), 0);
        rst_n = 1'b1;

        // R6: disabled, settings toggled, nothing happens
        cnt_act = 0;
        for (int i = 0; i < 60; i++) begin
            bit_div = 8'(i);
            prescale = 2'(i);
            @(negedge clk);
            if (scl_drive_low || fall_stb || rise_stb) cnt_act++;
        end
        chk("R6 idle activity", cnt_act, 0);

        // R2 R3 R5: table walk
        for (int v = 0; v < NV; v++) begin
            master_en = 1'b0;
            bit_div = 8'(VD[v]);
            prescale = 2'(VP[v]);
            repeat (2) @(negedge clk);
            master_en = 1'b1;
            wait_fall();
            measure(lo, hi, rs, rp);
            chk("R2 low length", lo, VH[v]);
            chk("R3 high length", hi, VH[v]);
            chk("R5 rise position", rp, 3);
            chk("R5 rise count", rs, 1);
        end

        // R4: slave stretching adds S cycles; rise strobe at S+3
        master_en = 1'b0;
        bit_div = 8'd4;
        prescale = 2'd0;
        stretch_len = 10;
        repeat (2) @(negedge clk);
        master_en = 1'b1;
        wait_fall();
        measure(lo, hi, rs, rp);
        chk("R4 stretched low", lo, 12);
        chk("R4 stretched high", hi, 22);
        chk("R5 stretched rise position", rp, 13);
        stretch_len = 0;

        // R7: change inside a period applies to the next period only
        master_en = 1'b0;
        repeat (2) @(negedge clk);
        master_en = 1'b1;
        wait_fall();
        bit_div = 8'd20;
        measure(lo, hi, rs, rp);
        chk("R7 current low", lo, 12);
        chk("R7 current high", hi, 12);
        measure(lo, hi, rs, rp);
        chk("R7 next low", lo, 28);
        chk("R7 next high", hi, 28);

        // R8: disable mid-low, release next cycle, restart with full low phase
        bit_div = 8'd6;
        wait_fall();
        repeat (3) @(negedge clk);
        master_en = 1'b0;
        @(negedge clk);
        chk("R8 release after disable", int'(scl_drive_low), 0);
        repeat (4) @(negedge clk);
        chk("R8 still released", int'(scl_drive_low), 0);
        master_en = 1'b1;
        wait_fall();
        measure(lo, hi, rs, rp);
        chk("R8 fresh low", lo, 14);
        chk("R8 fresh high", hi, 14);

        summary();
        $finish;
    end
endmodule